// File: doc/BRIEF.md
# Packed Signed Multiply Unit

This block multiplies two 64-bit operands as four independent signed 16-bit lanes. It offers five ways to shape the four 32-bit lane products into a 64-bit result. It can keep the upper or lower half of each product. It can add neighbouring products into two 32-bit lanes. It can take a rounded 16-bit slice of each product. Or it can add that rounded slice into a third operand. It serves as the multiply stage of a packed-integer datapath. The caller selects the register file entries, including any implied destination, and presents the three operands, a mode code and a valid strobe.

The unit has a fixed latency of two clock cycles. The first stage registers the four lane products together with the mode and the accumulator operand. The second stage registers the formatted result. The result register only loads when a valid operation reaches it, so between operations it keeps its last value.

Top module: `pmul_unit`

## Requirements
- R1: After reset, `valid_o` is 0 and `result_o` is all zeros.
- R2: `valid_o` equals `valid_i` from two rising edges earlier. `result_o` changes only when an accepted operation completes, and otherwise keeps its value.
- R3: Mode code 0 (high) puts bits 31:16 of the signed product of lane i of A and B into result bits 16i+15:16i.
- R4: Mode code 1 (low) puts bits 15:0 of each signed lane product into the same lane of the result.
- R5: Mode code 2 (multiply-add) puts the sum of products 3 and 2 in result bits 63:32 and the sum of products 1 and 0 in bits 31:0. Each sum wraps modulo 2^32, so four lanes of 8000h give 80000000h in both halves.
- R6: Mode code 3 (rounded high) adds 4000h to each lane product in 33-bit precision and returns bits 30:15. For 8000h times 8000h the lane result is 8000h.
- R7: Mode code 4 (accumulate) adds the rounded-high lane value of R6 to lane i of C, without saturation, modulo 2^16.
- R8: Mode codes 5 to 7 yield an all-zero result. C has no effect on the result in any mode except code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 3 | Mode code (0 high, 1 low, 2 multiply-add, 3 rounded high, 4 accumulate) |
| a_i | input | 64 | Operand A, four signed 16-bit lanes |
| b_i | input | 64 | Operand B, four signed 16-bit lanes |
| c_i | input | 64 | Accumulator operand, four 16-bit lanes |
| valid_o | output | 1 | Result valid, two cycles after valid_i |
| result_o | output | 64 | Registered result |

## Verification
The bench uses the default build: 16-bit lanes and four lanes. With these values the rounding constant is 4000h, the extracted slice is bits 30:15, and the 8000h-squared overflow sits in both the multiply-add and the rounded paths. Directed vectors cover those overflows, the wrap of the accumulate add, reserved mode codes and idle gaps. Back-to-back random operations in every mode, with random C, then test the pipeline and show that C is ignored outside accumulate mode.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [2:0] {
    MODE_HI   = 3'd0,
    MODE_LO   = 3'd1,
    MODE_MADD = 3'd2,
    MODE_RHI  = 3'd3,
    MODE_RACC = 3'd4
  } mode_e;
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int LANE_W = 16,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod;

  assign a_ext = $signed({{LANE_W{a_i[LANE_W-1]}}, a_i});
  assign b_ext = $signed({{LANE_W{b_i[LANE_W-1]}}, b_i});
  assign prod  = a_ext * b_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_o <= '0;
    else if (en_i) prod_o <= prod;
  end
endmodule

// File: rtl/pmul_format.sv
module pmul_format
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANES * LANE_W,
  localparam int PAIRS  = LANES / 2
) (
  input  mode_e                         mode_i,
  input  logic [LANES-1:0][PROD_W-1:0]  prod_i,
  input  logic [DATA_W-1:0]             c_i,
  output logic [DATA_W-1:0]             result_o
);
  localparam logic [PROD_W:0] RND = (PROD_W+1)'(1) << (LANE_W - 2);

  logic [DATA_W-1:0] hi_v, lo_v, rhi_v, acc_v, madd_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PROD_W:0] rsum;
    // 33-bit rounding add, then slice 30:15
    assign rsum = {prod_i[i][PROD_W-1], prod_i[i]} + RND;
    assign hi_v [i*LANE_W +: LANE_W] = prod_i[i][PROD_W-1 -: LANE_W];
    assign lo_v [i*LANE_W +: LANE_W] = prod_i[i][LANE_W-1:0];
    assign rhi_v[i*LANE_W +: LANE_W] = rsum[PROD_W-2 -: LANE_W];
    assign acc_v[i*LANE_W +: LANE_W] = c_i[i*LANE_W +: LANE_W] + rsum[PROD_W-2 -: LANE_W];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign madd_v[j*PROD_W +: PROD_W] = prod_i[2*j] + prod_i[2*j+1];
  end

  always_comb begin
    unique case (mode_i)
      MODE_HI:   result_o = hi_v;
      MODE_LO:   result_o = lo_v;
      MODE_MADD: result_o = madd_v;
      MODE_RHI:  result_o = rhi_v;
      MODE_RACC: result_o = acc_v;
      default:   result_o = '0;
    endcase
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic [LANES-1:0][PROD_W-1:0] prod_q;
  logic                         v1_q;
  mode_e                        mode_q;
  logic [DATA_W-1:0]            c_q;
  logic [DATA_W-1:0]            fmt;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pmul_lane #(.LANE_W(LANE_W)) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (valid_i),
      .a_i    (a_i[i*LANE_W +: LANE_W]),
      .b_i    (b_i[i*LANE_W +: LANE_W]),
      .prod_o (prod_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      mode_q <= MODE_HI;
      c_q    <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        mode_q <= mode_e'(mode_i);
        c_q    <= c_i;
      end
    end
  end

  pmul_format #(.LANE_W(LANE_W), .LANES(LANES)) i_format (
    .mode_i   (mode_q),
    .prod_i   (prod_q),
    .c_i      (c_q),
    .result_o (fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) result_o <= fmt;
    end
  end

  // cycles since reset, saturating; gates $past-depth-2 checks
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !valid_o) |-> $stable(result_o));

  p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && valid_o && $past(mode_i, 2) > 3'd4) |-> (result_o == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_lo_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd2 && valid_o && $past(mode_i, 2) == 3'd1) |->
      (result_o[i*LANE_W] == ($past(a_i[i*LANE_W], 2) & $past(b_i[i*LANE_W], 2))));

    p_hi_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd2 && valid_o && $past(mode_i, 2) == 3'd0 &&
       $past(a_i[i*LANE_W +: LANE_W], 2) != '0 && $past(b_i[i*LANE_W +: LANE_W], 2) != '0) |->
      (result_o[i*LANE_W + LANE_W-1] ==
       ($past(a_i[i*LANE_W + LANE_W-1], 2) ^ $past(b_i[i*LANE_W + LANE_W-1], 2))));

    p_acc_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd2 && valid_o && $past(mode_i, 2) == 3'd4 &&
       $past(a_i[i*LANE_W +: LANE_W], 2) == '0) |->
      (result_o[i*LANE_W +: LANE_W] == $past(c_i[i*LANE_W +: LANE_W], 2)));
  end
endmodule

// File: tb/test_pmul_unit.sv
module test_pmul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [63:0] a_i = '0, b_i = '0, c_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_cmp = 0, n_bad = 0;

  pmul_unit i_pmul_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .valid_o(valid_o), .result_o(result_o)
  );

  always #10 clk = ~clk;

  // reference pipeline
  logic        s1_v = 0, out_v = 0;
  logic [63:0] s1_res = 0, out_res = 0;
  logic [2:0]  s1_mode = 0, out_mode = 0;

  function automatic logic [63:0] ref_model(logic [2:0] m, logic [63:0] a, logic [63:0] b, logic [63:0] c);
    longint p[4];
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++)
      p[i] = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
    for (int i = 0; i < 4; i++) begin
      longint rh = ((p[i] + 16384) >>> 15) & 16'hFFFF;
      case (m)
        3'd0: r[16*i +: 16] = 16'((p[i] >>> 16) & 16'hFFFF);
        3'd1: r[16*i +: 16] = 16'(p[i] & 16'hFFFF);
        3'd3: r[16*i +: 16] = 16'(rh);
        3'd4: r[16*i +: 16] = 16'((longint'(c[16*i +: 16]) + rh) & 16'hFFFF);
        default: ;
      endcase
    end
    if (m == 3'd2) begin
      r[31:0]  = 32'((p[0] + p[1]) & 32'hFFFFFFFF);
      r[63:32] = 32'((p[2] + p[3]) & 32'hFFFFFFFF);
    end
    return r;
  endfunction

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(string rq);
    n_cmp++;
    if (valid_o !== out_v) begin
      n_bad++;
      $display("FAIL %s valid_o actual=%0b expected=%0b", rq, valid_o, out_v);
    end else if (result_o !== out_res) begin
      n_bad++;
      $display("FAIL %s result_o actual=%h expected=%h", rq, result_o, out_res);
    end
  endtask

  task automatic step(logic v, logic [2:0] m, logic [63:0] a, logic [63:0] b, logic [63:0] c);
    @(negedge clk);
    // R2 on idle/valid timing, else the mode requirement of the result shown
    compare(out_v ? req_of(out_mode) : "R2");
    valid_i = v; mode_i = m; a_i = a; b_i = b; c_i = c;
    out_v = s1_v;
    if (s1_v) begin out_res = s1_res; out_mode = s1_mode; end
    s1_v = v;
    if (v) begin s1_res = ref_model(m, a, b, c); s1_mode = m; end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (valid_o !== 1'b0 || result_o !== 64'h0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%0b/%h expected=0/0", valid_o, result_o);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R3/R4 signs and extremes
    step(1, 0, 64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFB, 64'h1234_5678_9ABC_DEF0);
    step(1, 1, 64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFB, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: 8000h overflow wraps to 80000000h
    step(1, 2, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'hAAAA_AAAA_AAAA_AAAA);
    step(1, 2, 64'h7FFF_0001_FFFF_1234, 64'h7FFF_FFFF_FFFF_F00D, 64'h0);
    // R6: rounding corners and 8000h case
    step(1, 3, 64'h8000_0001_4000_FFFF, 64'h8000_4000_0001_4000, 64'h5555_5555_5555_5555);
    step(1, 3, 64'h0001_0001_FFFF_7FFF, 64'h3FFF_4001_C001_8001, 64'h0);
    // R7: wrap on accumulate, zero operand passes C
    step(1, 4, 64'h8000_7FFF_0000_0100, 64'h8000_7FFF_1234_0100, 64'h8000_FFFF_BEEF_0001);
    // R8: reserved codes
    step(1, 5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h9999_9999_9999_9999);
    step(1, 7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R2: idle gap must hold result
    for (int k = 0; k < 4; k++) step(0, 3'd2, {$urandom, $urandom}, {$urandom, $urandom}, 64'h0);
    step(1, 6, 64'h1, 64'h1, 64'h1);
    step(0, 0, 0, 0, 0);
    step(1, 1, 64'h0003_0005_0007_0009, 64'h0002_0004_0006_0008, 64'hDEAD_BEEF_0000_0000);
    // random, all modes, random C (R8 second clause)
    for (int k = 0; k < 600; k++) begin
      logic v = ($urandom % 5) != 0;
      step(v, 3'($urandom % 8), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule